// File: doc/BRIEF.md
# Back-Pressure-Aware Read Buffer

This block sits between user logic that produces a stream of data words and a memory-mapped read master that drains them. The producer offers a word together with a valid strobe. The buffer stores the word in an internal first-in, first-out store and raises a ready flag while it has room. The read side takes one word per cycle unless the bus reports a stall. Each word that leaves appears on a registered data output, together with a strobe that marks it as real.

A stalled bus blocks every read. The store then fills up. Once it holds its full depth, ready drops so the producer stops sending and no word is lost. The word width, the store depth and the number format of the words are parameters. The format is signed integer, signed fractional with a set count of fraction bits, or unsigned integer. Words pass through bit for bit in every format.

Top module: `rdbuf_stream`

## Requirements
- R1: A word on `in_data` is stored only in a cycle where `in_valid` is high and `ready` is high; a word offered while `ready` is low is discarded.
- R2: In any cycle where `stall` is high, no word is read, and `out_valid` is low in the following cycle.
- R3: `ready` is low exactly when the store holds `DEPTH` words; occupancy never exceeds `DEPTH`.
- R4: In any cycle where `stall` is low and the store is not empty, one word is read; it appears on `out_data` with `out_valid` high in the next cycle.
- R5: Words leave in the order they were stored.
- R6: A store and a read in the same cycle leave the occupancy unchanged.
- R7: The number format (signed integer, signed fractional, unsigned integer) and the fraction-bit count are parameters; the fraction-bit count must be below `WIDTH` for the fractional format and zero otherwise; every word is delivered with all `WIDTH` bits unchanged.
- R8: A synchronous reset (`rst` high at a clock edge) empties the store and drives `out_valid` low; `ready` is high after it.
- R9: `out_valid` is high in a cycle only if a word was read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | WIDTH | Word from the producer |
| in_valid | input | 1 | Producer strobe for `in_data` |
| stall | input | 1 | Bus back-pressure; blocks reads while high |
| ready | output | 1 | Room for at least one more word |
| out_data | output | WIDTH | Word delivered to the bus side (registered) |
| out_valid | output | 1 | High when `out_data` carries a delivered word |

## Verification
The bench holds the bus stalled until the store is full. It then keeps offering words. A design that dropped ready late, or that wrapped its pointers, would overwrite the oldest word or deliver a stray one. That shows up as a wrong value in the drain sequence. With the store one short of full, the bench streams with stores and reads in the same cycle and then stalls once. A wrong occupancy update would make ready drop too early or too late. A reset while the store is full must leave nothing to drain; stale pointers would produce valid strobes afterwards. Negative fractional words check that no bit is altered.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;

    typedef enum logic [1:0] {
        NUM_SINT  = 2'd0,
        NUM_SFRAC = 2'd1,
        NUM_UINT  = 2'd2
    } num_fmt_e;

endpackage

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          stall,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          ready,
    output logic          out_valid
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          vld;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        ready  = (st_q.count < FULL_CNT);
        wr_en  = in_valid && ready;
        rd_en  = !stall && (st_q.count != '0);

        if (wr_en) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (rd_en) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({wr_en, rd_en})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
        st_d.vld = rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr   = st_q.wr_ptr;
    assign rd_addr   = st_q.rd_ptr;
    assign out_valid = st_q.vld;

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= FULL_CNT);

    // R6
    a_r6_occupancy_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> (st_q.count == $past(st_q.count)));

    // R9
    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !out_valid);

endmodule

// File: rtl/rdbuf_store.sv
module rdbuf_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_data_d, rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) begin
            rd_data_d = mem_q[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data = rd_data_q;

    // R1
    a_r1_no_same_slot: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |-> (wr_addr != rd_addr));

endmodule

// File: rtl/rdbuf_stream.sv
module rdbuf_stream
    import rdbuf_pkg::*;
#(
    parameter int       WIDTH     = 16,
    parameter int       DEPTH     = 8,
    parameter num_fmt_e NUM_FMT   = NUM_SINT,
    parameter int       FRAC_BITS = 0,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    input  logic             stall,
    output logic             ready,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);

    generate
        if (NUM_FMT == NUM_SFRAC) begin : g_frac_chk
            if (FRAC_BITS < 0 || FRAC_BITS >= WIDTH) begin : g_bad
                $error("fraction bits must be below the word width");
            end
        end else begin : g_int_chk
            if (FRAC_BITS != 0) begin : g_bad
                $error("integer formats carry no fraction bits");
            end
        end
        if (DEPTH < 2) begin : g_depth_chk
            $error("depth must be at least two");
        end
    endgenerate

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;

    rdbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .stall     (stall),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .ready     (ready),
        .out_valid (out_valid)
    );

    rdbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q && !rst) begin
            // R8
            a_r8_reset_clears: assert (!out_valid && ready);
        end
    end

    // R2
    a_r2_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);

    // R1
    a_r1_write_needs_room: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ready);

endmodule

// File: tb/test_rdbuf_stream.sv
module test_rdbuf_stream;
    import rdbuf_pkg::*;

    localparam int W = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] in_data;
    logic         in_valid;
    logic         stall;
    logic         ready;
    logic [W-1:0] out_data;
    logic         out_valid;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] model_q[$];
    logic         exp_v;
    logic [W-1:0] exp_d;

    always #5 clk = ~clk;

    rdbuf_stream #(.WIDTH(W), .DEPTH(D), .NUM_FMT(NUM_SFRAC), .FRAC_BITS(8)) i_rdbuf_stream (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .stall(stall), .ready(ready), .out_data(out_data), .out_valid(out_valid)
    );

    task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check outputs at the falling edge, drive, advance the model.
    task automatic step(input logic v, input logic [W-1:0] d, input logic s, input string tag);
        int old;
        logic rd;
        @(negedge clk);
        chk(ready == (model_q.size() < D), {tag, " R3 ready"}, W'(ready), W'(model_q.size() < D));
        chk(out_valid == exp_v, {tag, " R9 valid"}, W'(out_valid), W'(exp_v));
        if (exp_v) chk(out_data == exp_d, {tag, " R5 data"}, out_data, exp_d);
        in_valid = v;
        in_data  = d;
        stall    = s;
        old = model_q.size();
        rd  = !s && (old > 0);
        exp_v = rd;
        if (rd) exp_d = model_q.pop_front();
        if (v && old < D) model_q.push_back(d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; stall = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        exp_v = 1'b0;
        chk(out_valid == 1'b0, "R8 valid after reset", W'(out_valid), '0);
        chk(ready == 1'b1, "R8 ready after reset", W'(ready), W'(1));
    endtask

    // R4 R7: free-running stream of signed fractional words
    task automatic t_stream();
        for (int i = 0; i < 6; i++) step(1'b1, W'(16'hFF80 - 16'(i * 37)), 1'b0, "R4 stream");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, "R7 tail");
    endtask

    // R2 R3 R1: stall until full, push past full, then drain
    task automatic t_fill_drain();
        for (int i = 0; i < D; i++) step(1'b1, W'(16'h8000 + 16'(i)), 1'b1, "R2 fill");
        for (int i = 0; i < 3; i++) step(1'b1, W'(16'hDEAD), 1'b1, "R1 over full");
        for (int i = 0; i < D + 3; i++) step(1'b0, '0, 1'b0, "R5 drain");
    endtask

    // R6: hold occupancy one short of full while storing and reading together
    task automatic t_same_cycle();
        for (int i = 0; i < D - 1; i++) step(1'b1, W'(16'h1000 + 16'(i)), 1'b1, "R6 prefill");
        for (int i = 0; i < 5; i++) step(1'b1, W'(16'h2000 + 16'(i)), 1'b0, "R6 both");
        step(1'b1, W'(16'h3000), 1'b1, "R6 top off");
        step(1'b0, '0, 1'b1, "R6 full");
        for (int i = 0; i < D + 2; i++) step(1'b0, '0, 1'b0, "R6 drain");
    endtask

    // R8: reset while full leaves nothing to drain
    task automatic t_reset_full();
        for (int i = 0; i < D; i++) step(1'b1, W'(16'h4000 + 16'(i)), 1'b1, "R8 fill");
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, "R8 empty");
        step(1'b1, W'(16'hA5A5), 1'b0, "R8 restart");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, "R8 restart out");
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; stall = 1'b0;
        exp_v = 1'b0; exp_d = '0;
        repeat (2) @(posedge clk);
        do_reset();
        t_stream();
        t_fill_drain();
        t_same_cycle();
        t_reset_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule